// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block moves a data word by exactly one bit position in a direction and with a fill rule chosen by a 3-bit operation code. The code selects one of eight variants: unchanged transfer, logical right shift, left shift, sign-preserving right shift, plain rotate left or right, and rotate left or right through a one-bit carry flag. The left shift serves as both the logical and the arithmetic form.

The result word and the carry-out bit are combinational functions of the input word, the operation code and the stored carry flag. The carry flag is a register inside the block. It is loaded from the carry-out on a clock edge only when the write strobe is high and a through-carry rotate is selected. A companion ALU can therefore chain rotates through carry across several words, one word per cycle.

Top module: `sstep_shift_unit`

## Requirements
- R1: Op code 3'b000 drives `data_out` equal to `data_in`.
- R2: Op code 3'b001 gives a logical right shift: `data_out[W-1]` is 0, each other bit i takes `data_in[i+1]`, and bit 0 of the input is dropped.
- R3: Op code 3'b010 gives a left shift: `data_out[0]` is 0, each other bit i takes `data_in[i-1]`, and the top input bit is dropped.
- R4: Op code 3'b011 gives an arithmetic right shift: the top bit keeps its input value, and each lower bit i takes `data_in[i+1]`.
- R5: Op code 3'b100 rotates left, with the top input bit landing in bit 0. Op code 3'b101 rotates right, with input bit 0 landing in the top bit.
- R6: Op code 3'b110 rotates left through carry: `data_out[0]` equals the stored `cy_flag`, and `cy_out` equals `data_in[W-1]`.
- R7: Op code 3'b111 rotates right through carry: `data_out[W-1]` equals the stored `cy_flag`, and `cy_out` equals `data_in[0]`.
- R8: `cy_out_vld` is 1 exactly when the op code is 3'b110 or 3'b111.
- R9: On a rising clock edge with reset low, `cy_flag` takes `cy_out` if `cy_wr` is 1 and the op code is 3'b110 or 3'b111. In every other case it keeps its value, including when `cy_wr` is high with any other op code.
- R10: A synchronous active-high `rst` clears `cy_flag` to 0 and takes priority over a carry write in the same cycle.
- R11: For op codes 3'b000 to 3'b101, `cy_out` shows the bit pushed out of the word: 0 for op 000, `data_in[0]` for ops 001, 011 and 101, and `data_in[W-1]` for ops 010 and 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | W (8) | Word to shift |
| op_sel | input | 3 | Operation code |
| cy_wr | input | 1 | Strobe that requests a carry flag update |
| data_out | output | W (8) | Word moved by one position |
| cy_out | output | 1 | Bit leaving the word |
| cy_out_vld | output | 1 | High for the two through-carry rotates |
| cy_flag | output | 1 | Stored carry flag |

## Verification
Two things can happen in the same cycle during a through-carry rotate with the strobe high. The result reads the stored flag, and the flag is overwritten by the bit that leaves the word. The bench provokes this by chaining rotates with alternating edge bits. It checks that the result combines the old flag value before the edge, and that the flag holds the outgoing bit after the edge. A reset raised together with a carry write that would load 1 is the second overlap, and the bench expects the flag to be 0 afterwards.

// File: rtl/sstep_pkg.sv
package sstep_pkg;
  typedef enum logic [2:0] {
    OP_PASS = 3'b000,
    OP_LSR  = 3'b001,
    OP_SHL  = 3'b010,
    OP_ASR  = 3'b011,
    OP_ROL  = 3'b100,
    OP_ROR  = 3'b101,
    OP_RLC  = 3'b110,
    OP_RRC  = 3'b111
  } sstep_op_e;
endpackage

// File: rtl/sstep_lane_mux.sv
module sstep_lane_mux
  import sstep_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  input  sstep_op_e    op,
  input  logic         cin,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic r_lsr, r_asr, r_ror, r_rrc;
    logic l_shl, l_rol, l_rlc;

    if (i == W-1) begin : g_top
      assign r_lsr = 1'b0;
      assign r_asr = d[W-1];
      assign r_ror = d[0];
      assign r_rrc = cin;
    end else begin : g_mid_r
      assign r_lsr = d[i+1];
      assign r_asr = d[i+1];
      assign r_ror = d[i+1];
      assign r_rrc = d[i+1];
    end

    if (i == 0) begin : g_bot
      assign l_shl = 1'b0;
      assign l_rol = d[W-1];
      assign l_rlc = cin;
    end else begin : g_mid_l
      assign l_shl = d[i-1];
      assign l_rol = d[i-1];
      assign l_rlc = d[i-1];
    end

    always_comb begin
      case (op)
        OP_PASS: q[i] = d[i];
        OP_LSR:  q[i] = r_lsr;
        OP_SHL:  q[i] = l_shl;
        OP_ASR:  q[i] = r_asr;
        OP_ROL:  q[i] = l_rol;
        OP_ROR:  q[i] = r_ror;
        OP_RLC:  q[i] = l_rlc;
        OP_RRC:  q[i] = r_rrc;
        default: q[i] = d[i];
      endcase
    end
  end
endmodule

// File: rtl/sstep_carry_pick.sv
module sstep_carry_pick
  import sstep_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  input  sstep_op_e    op,
  output logic         co,
  output logic         co_vld
);
  localparam int TOP = W - 1;

  always_comb begin
    co     = 1'b0;
    co_vld = 1'b0;
    case (op)
      OP_PASS: co = 1'b0;
      OP_LSR, OP_ASR, OP_ROR: co = d[0];
      OP_SHL, OP_ROL: co = d[TOP];
      OP_RLC: begin
        co     = d[TOP];
        co_vld = 1'b1;
      end
      OP_RRC: begin
        co     = d[0];
        co_vld = 1'b1;
      end
      default: co = 1'b0;
    endcase
  end
endmodule

// File: rtl/sstep_flag_reg.sv
module sstep_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  input  logic co_vld,
  input  logic co,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (wr_req && co_vld)
      flag <= co;
  end
endmodule

// File: rtl/sstep_shift_unit.sv
module sstep_shift_unit
  import sstep_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_in,
  input  logic [2:0]   op_sel,
  input  logic         cy_wr,
  output logic [W-1:0] data_out,
  output logic         cy_out,
  output logic         cy_out_vld,
  output logic         cy_flag
);
  sstep_op_e op;
  assign op = sstep_op_e'(op_sel);

  sstep_lane_mux #(.W(W)) u_lanes (
    .d   (data_in),
    .op  (op),
    .cin (cy_flag),
    .q   (data_out)
  );

  sstep_carry_pick #(.W(W)) u_carry (
    .d      (data_in),
    .op     (op),
    .co     (cy_out),
    .co_vld (cy_out_vld)
  );

  sstep_flag_reg u_flag (
    .clk    (clk),
    .rst    (rst),
    .wr_req (cy_wr),
    .co_vld (cy_out_vld),
    .co     (cy_out),
    .flag   (cy_flag)
  );
endmodule

// File: rtl/sstep_shift_unit_chk.sv
module sstep_shift_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] data_in,
  input logic [2:0]   op_sel,
  input logic         cy_wr,
  input logic [W-1:0] data_out,
  input logic         cy_out,
  input logic         cy_out_vld,
  input logic         cy_flag
);
  assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b000) |-> (data_out == data_in));

  assert_asr_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b011) |-> (data_out[W-1] == data_in[W-1]));

  assert_rlc_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b110) |-> (data_out[0] == cy_flag));

  assert_rrc_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'b111) |-> (data_out[W-1] == cy_flag));

  assert_vld_ops_R8: assert property (@(posedge clk) disable iff (rst)
    cy_out_vld |-> (op_sel[2] && op_sel[1]));

  assert_flag_load_R9: assert property (@(posedge clk) disable iff (rst)
    (cy_wr && op_sel[2] && op_sel[1]) |=> (cy_flag == $past(cy_out)));

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(cy_wr && op_sel[2] && op_sel[1]) |=> $stable(cy_flag));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> !cy_flag);
endmodule

bind sstep_shift_unit sstep_shift_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .data_in    (data_in),
  .op_sel     (op_sel),
  .cy_wr      (cy_wr),
  .data_out   (data_out),
  .cy_out     (cy_out),
  .cy_out_vld (cy_out_vld),
  .cy_flag    (cy_flag)
);

// File: tb/test_sstep_shift_unit.sv
module test_sstep_shift_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] data_in = '0;
  logic [2:0]   op_sel = 3'b000;
  logic         cy_wr = 1'b0;
  logic [W-1:0] data_out;
  logic         cy_out, cy_out_vld, cy_flag;

  int total = 0;
  int bad = 0;
  logic mf = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sstep_shift_unit #(.W(W)) i_sstep_shift_unit (
    .clk(clk), .rst(rst), .data_in(data_in), .op_sel(op_sel), .cy_wr(cy_wr),
    .data_out(data_out), .cy_out(cy_out), .cy_out_vld(cy_out_vld), .cy_flag(cy_flag)
  );

  function automatic logic [W:0] model(input logic [2:0] o, input logic [W-1:0] d, input logic c);
    case (o)
      3'b000: model = {1'b0, d};
      3'b001: model = {d[0], 1'b0, d[W-1:1]};
      3'b010: model = {d[W-1], d[W-2:0], 1'b0};
      3'b011: model = {d[0], d[W-1], d[W-1:1]};
      3'b100: model = {d[W-1], d[W-2:0], d[W-1]};
      3'b101: model = {d[0], d[0], d[W-1:1]};
      3'b110: model = {d[W-1], d[W-2:0], c};
      default: model = {d[0], c, d[W-1:1]};
    endcase
  endfunction

  function automatic string res_tag(input logic [2:0] o);
    case (o)
      3'b000: res_tag = "R1";
      3'b001: res_tag = "R2";
      3'b010: res_tag = "R3";
      3'b011: res_tag = "R4";
      3'b100, 3'b101: res_tag = "R5";
      3'b110: res_tag = "R6";
      default: res_tag = "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [W-1:0] d, input logic w);
    logic [W:0] e;
    @(negedge clk);
    op_sel = o; data_in = d; cy_wr = w;
    #4;
    e = model(o, d, mf);
    chk(res_tag(o), 32'(data_out), 32'(e[W-1:0]));
    chk((o[2] && o[1]) ? res_tag(o) : "R11", 32'(cy_out), 32'(e[W]));
    chk("R8", 32'(cy_out_vld), 32'(o[2] && o[1]));
    @(posedge clk);
    #1;
    if (w && o[2] && o[1]) mf = e[W];
    chk("R9", 32'(cy_flag), 32'(mf));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk);
    #1;
    chk("R10", 32'(cy_flag), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // directed corners, every op with both flag values
    for (int c = 0; c < 2; c++) begin
      run(3'b110, c[0] ? 8'h80 : 8'h00, 1'b1);
      for (int o = 0; o < 8; o++) begin
        run(3'(o), 8'h80, 1'b0);
        run(3'(o), 8'h01, 1'b0);
        run(3'(o), 8'hFF, 1'b0);
        run(3'(o), 8'h00, 1'b0);
        run(3'(o), 8'h5A, 1'b0);
      end
    end

    // R9: strobe with non-carry ops must not touch the flag
    run(3'b110, 8'h80, 1'b1);
    for (int o = 0; o < 6; o++) run(3'(o), 8'h00, 1'b1);
    run(3'b111, 8'h00, 1'b1);
    for (int o = 0; o < 6; o++) run(3'(o), 8'hFF, 1'b1);

    // chained rotates through carry with alternating edge bits
    for (int k = 0; k < 16; k++) begin
      run(3'b110, k[0] ? 8'h7F : 8'h80, 1'b1);
      run(3'b111, k[1] ? 8'hFE : 8'h01, 1'b1);
    end

    // R10: reset wins over a carry write that would load 1
    run(3'b110, 8'h80, 1'b1);
    @(negedge clk);
    rst = 1'b1; op_sel = 3'b111; data_in = 8'hFF; cy_wr = 1'b1;
    @(posedge clk);
    #1;
    mf = 1'b0;
    chk("R10", 32'(cy_flag), 32'd0);
    @(negedge clk);
    rst = 1'b0; cy_wr = 1'b0;

    // constrained random
    for (int n = 0; n < 600; n++) begin
      run(3'($urandom_range(0, 7)), 8'($urandom), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule